// File: doc/BRIEF.md
# Column Driver Host Bus Bridge

This block sits between a host processor bus and the pixel storage of one column driver. Up to four drivers share a single 17-bit address space. Each driver is given a 2-bit placement number. It claims only the quarter of the screen that belongs to that number, plus its own run of gray-level map entries. Host cycles that hit the owned pixel area become accesses on a synchronous, word-wide RAM port with byte enables. Pixels are packed four bits each, and within every byte the low nibble is the left pixel of the pair.

The gray-level map translates each 4-bit pixel code into a 6-bit drive level. The panel refresh logic reads it through a separate lookup port. Reset loads the map with a fixed spread of levels.

The pixel RAM has a single port. The refresh side raises a request input whenever it needs the array, and that request always takes priority. The bridge lowers its ready output while a host pixel access waits for the array or is being served. Ready stays low for as long as refresh traffic delays the access. Both a 16-bit bus with byte lanes and an 8-bit bus are supported.

Top module: `gsd_host_bridge`

## Requirements
- R1: After reset, ready is high, no read lane is driven, and the lookup port returns levels 0,4,8,12,16,19,21,23,25,27,29,32,36,40,44,48 for codes 0 to 15.
- R2: The address splits into a line number (bits 16:8) and a byte offset (bits 7:0). Placement bit 1 selects offsets 78h–EFh (when set) or 00h–77h. Placement bit 0 selects lines A0h–13Fh (when set) or 00h–9Fh. The RAM word address is (line − line base) × 60 + ((offset − offset base) >> 1).
- R3: A host cycle outside the owned area, including any line above 13Fh, causes no RAM access and drives no read lane, and ready stays high.
- R4: A write to an even address 1FF80h + 20h×placement + 2×i (i = 0..15) stores data bits 5:0 in map entry i. Writes to odd addresses and to the runs of the other placements change no entry.
- R5: A read of an owned map entry returns the level in bits 5:0 with all higher bits zero, and drives only the low lane (lane mask 01).
- R6: On the 16-bit bus (narrow low), byte enables are {upper-byte-enable active, A0 low}. Both low selects the word (11). Upper-byte-enable inactive with A0 low selects the low lane (01). Upper-byte-enable active with A0 high selects the high lane (10). Upper-byte-enable inactive with A0 high selects nothing, and the cycle is ignored. Write data passes unchanged. Read data is the whole RAM word, and the lane mask equals the byte enables.
- R7: On the 8-bit bus (narrow high), A0 picks the byte (1 = high byte) and the upper data lane and upper-byte-enable are ignored. Write data is the low byte copied to both lanes. Read data is the selected byte in bits 7:0 with lane mask 01.
- R8: For a pixel access with no refresh traffic, ready is low for exactly 1 cycle on a write and exactly 2 cycles on a read, starting at the clock edge that samples the strobes. Map and unclaimed cycles never lower ready.
- R9: The RAM port is never enabled while the refresh request is high. The host access is issued at the first edge with no request, so each busy cycle lengthens the wait by one.
- R10: Read data and the lane mask stay constant while chip select and the read strobe stay low. After the strobes are released, the lanes are undriven from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| place | input | 2 | Placement number of this driver |
| narrow | input | 1 | High selects the 8-bit bus |
| addr | input | 17 | Host byte address |
| sel_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ube_n | input | 1 | Upper byte enable, active low |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data |
| rdata_en | output | 2 | Lane drive mask for read data (bit 1 = upper lane) |
| ready | output | 1 | High when the host may finish the cycle |
| ref_req | input | 1 | Refresh side claims the RAM this cycle |
| ram_en | output | 1 | RAM port enable |
| ram_we | output | 1 | RAM port write |
| ram_addr | output | 14 | RAM word address |
| ram_be | output | 2 | RAM byte enables |
| ram_wdata | output | 16 | RAM write word |
| ram_rdata | input | 16 | RAM read word, valid one cycle after an enabled read |
| pal_sel | input | 4 | Pixel code for the level lookup |
| pal_level | output | 6 | Drive level for pal_sel |

## Verification
Strobes are driven at a falling edge. The first rising edge samples them, so a pixel write enables the RAM port in the cycle that follows. Ready returns one cycle later, plus one more cycle on a read for the RAM latency, plus one cycle for every cycle the refresh request stays high. Map accesses and unclaimed cycles complete at that first edge, so their results are visible at the next falling edge. The bench counts the falling edges at which ready is low and compares that count with these figures. A scoreboard checks each RAM port transaction one time unit after the falling edge, and the lookup port is read combinationally after each map write.

// File: rtl/gsd_pkg.sv
package gsd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_FETCH = 2'd2,
      ST_HOLD  = 2'd3
   } gsd_state_e;

   // stock 16-step level spread loaded at reset
   function automatic int gsd_stock_level(input int code);
      case (code)
         0:  return 0;
         1:  return 4;
         2:  return 8;
         3:  return 12;
         4:  return 16;
         5:  return 19;
         6:  return 21;
         7:  return 23;
         8:  return 25;
         9:  return 27;
         10: return 29;
         11: return 32;
         12: return 36;
         13: return 40;
         14: return 44;
         default: return 48;
      endcase
   endfunction

endpackage

// File: rtl/gsd_addr_decode.sv
module gsd_addr_decode #(
   parameter int ADDR_W    = 17,
   parameter int ROW_BYTES = 120,
   parameter int ROWS      = 160,
   parameter int RAM_AW    = 14,
   parameter int PAL_N     = 16,
   parameter int PAL_IW    = 4,
   parameter logic [ADDR_W-1:0] PAL_BASE = 'h1FF80
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        place,
   output logic              ram_hit,
   output logic [RAM_AW-1:0] word_addr,
   output logic              pal_hit,
   output logic [PAL_IW-1:0] pal_idx
);
   localparam int LINE_W   = ADDR_W - 8;
   localparam int ROW_WRDS = ROW_BYTES / 2;
   localparam int PAL_SPAN = PAL_N * 2 * 4;

   logic [8:0]        col_base, col_rel;
   logic [LINE_W-1:0] line, line_base, line_rel;
   logic [ADDR_W-1:0] prel;
   logic              col_ok, line_ok;

   always_comb begin
      line      = addr[ADDR_W-1:8];
      col_base  = place[1] ? 9'(ROW_BYTES) : 9'd0;
      line_base = place[0] ? LINE_W'(ROWS) : '0;
      col_rel   = {1'b0, addr[7:0]} - col_base;
      line_rel  = line - line_base;
      col_ok    = ({1'b0, addr[7:0]} >= col_base) && (col_rel < 9'(ROW_BYTES));
      line_ok   = (line >= line_base) && (line_rel < LINE_W'(ROWS));
      ram_hit   = col_ok && line_ok;
      word_addr = RAM_AW'(line_rel) * RAM_AW'(ROW_WRDS) + RAM_AW'(col_rel[8:1]);

      prel    = addr - PAL_BASE;
      pal_hit = (addr >= PAL_BASE) && (prel < ADDR_W'(PAL_SPAN)) &&
                (prel[PAL_IW+2 -: 2] == place) && !addr[0];
      pal_idx = prel[PAL_IW:1];
   end
endmodule

// File: rtl/gsd_palette.sv
module gsd_palette #(
   parameter int PAL_N  = 16,
   parameter int PAL_IW = 4,
   parameter int LVL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PAL_IW-1:0] widx,
   input  logic [LVL_W-1:0]  wlvl,
   input  logic [PAL_IW-1:0] ridx_a,
   output logic [LVL_W-1:0]  rlvl_a,
   input  logic [PAL_IW-1:0] ridx_b,
   output logic [LVL_W-1:0]  rlvl_b
);
   logic [PAL_N*LVL_W-1:0] flat;

   for (genvar i = 0; i < PAL_N; i++) begin : g_ent
      localparam int INIT = (PAL_N == 16) ? gsd_pkg::gsd_stock_level(i)
                                          : (i * 48) / (PAL_N - 1);
      logic [LVL_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        q <= LVL_W'(INIT);
         else if (we && widx == PAL_IW'(i)) q <= wlvl;
      end
      assign flat[i*LVL_W +: LVL_W] = q;
   end

   assign rlvl_a = flat[ridx_a*LVL_W +: LVL_W];
   assign rlvl_b = flat[ridx_b*LVL_W +: LVL_W];
endmodule

// File: rtl/gsd_lane_steer.sv
module gsd_lane_steer #(
   parameter int DATA_W = 16
) (
   input  logic              narrow,
   input  logic              a0,
   input  logic              ube_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [1:0]        be,
   output logic [DATA_W-1:0] wword
);
   localparam int HALF = DATA_W / 2;

   always_comb begin
      if (narrow) begin
         be    = a0 ? 2'b10 : 2'b01;
         wword = {wdata[HALF-1:0], wdata[HALF-1:0]};
      end else begin
         be    = {!ube_n, !a0};
         wword = wdata;
      end
   end
endmodule

// File: rtl/gsd_host_bridge.sv
module gsd_host_bridge #(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 16,
   parameter int LVL_W     = 6,
   parameter int PAL_N     = 16,
   parameter int PAL_IW    = $clog2(PAL_N),
   parameter int ROW_BYTES = 120,
   parameter int ROWS      = 160,
   parameter int RAM_AW    = $clog2(ROWS * ROW_BYTES / 2),
   parameter logic [ADDR_W-1:0] PAL_BASE = 'h1FF80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        place,
   input  logic              narrow,
   input  logic [ADDR_W-1:0] addr,
   input  logic              sel_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              ube_n,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rdata_en,
   output logic              ready,
   input  logic              ref_req,
   output logic              ram_en,
   output logic              ram_we,
   output logic [RAM_AW-1:0] ram_addr,
   output logic [1:0]        ram_be,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   input  logic [PAL_IW-1:0] pal_sel,
   output logic [LVL_W-1:0]  pal_level
);
   import gsd_pkg::*;

   localparam int HALF = DATA_W / 2;

   if (DATA_W != 16) begin : g_bad_width
      $error("bus width must be 16");
   end
   if (LVL_W < 6) begin : g_bad_level
      $error("level field too narrow for 0..48");
   end
   if ((ROW_BYTES % 2) != 0 || 2 * ROW_BYTES > 256) begin : g_bad_row
      $error("row bytes must be even and two regions must fit in one offset byte");
   end
   if ((2 ** RAM_AW) < (ROWS * ROW_BYTES / 2)) begin : g_bad_ram
      $error("RAM address too narrow");
   end

   gsd_state_e        state_q;
   logic              ram_hit, pal_hit, start, release_c, pal_we;
   logic [RAM_AW-1:0] word_addr, addr_q;
   logic [PAL_IW-1:0] pal_idx;
   logic [1:0]        lane_be, be_q, drive_q;
   logic [DATA_W-1:0] lane_word, wd_q, fetched;
   logic [LVL_W-1:0]  pal_host_lvl;
   logic              we_q;

   gsd_addr_decode #(
      .ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES), .ROWS(ROWS), .RAM_AW(RAM_AW),
      .PAL_N(PAL_N), .PAL_IW(PAL_IW), .PAL_BASE(PAL_BASE)
   ) u_dec (
      .addr(addr), .place(place), .ram_hit(ram_hit), .word_addr(word_addr),
      .pal_hit(pal_hit), .pal_idx(pal_idx)
   );

   gsd_lane_steer #(.DATA_W(DATA_W)) u_lane (
      .narrow(narrow), .a0(addr[0]), .ube_n(ube_n), .wdata(wdata),
      .be(lane_be), .wword(lane_word)
   );

   gsd_palette #(.PAL_N(PAL_N), .PAL_IW(PAL_IW), .LVL_W(LVL_W)) u_pal (
      .clk(clk), .rst_n(rst_n), .we(pal_we), .widx(pal_idx),
      .wlvl(wdata[LVL_W-1:0]), .ridx_a(pal_idx), .rlvl_a(pal_host_lvl),
      .ridx_b(pal_sel), .rlvl_b(pal_level)
   );

   assign start     = !sel_n && (rd_n != wr_n);
   assign release_c = sel_n || (rd_n && wr_n);
   assign pal_we    = (state_q == ST_IDLE) && start && pal_hit && !wr_n;
   assign fetched   = narrow ? {{HALF{1'b0}}, (be_q[1] ? ram_rdata[DATA_W-1:HALF]
                                                       : ram_rdata[HALF-1:0])}
                             : ram_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ready   <= 1'b1;
         rdata   <= '0;
         drive_q <= '0;
         we_q    <= 1'b0;
         addr_q  <= '0;
         be_q    <= '0;
         wd_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (start) begin
               we_q   <= !wr_n;
               addr_q <= word_addr;
               be_q   <= lane_be;
               wd_q   <= lane_word;
               if (ram_hit && lane_be != 2'b00) begin
                  state_q <= ST_ISSUE;
                  ready   <= 1'b0;
               end else begin
                  state_q <= ST_HOLD;
                  if (pal_hit && wr_n) begin
                     rdata   <= DATA_W'(pal_host_lvl);
                     drive_q <= 2'b01;
                  end
               end
            end
            ST_ISSUE: if (!ref_req) begin
               if (we_q) begin
                  state_q <= ST_HOLD;
                  ready   <= 1'b1;
               end else begin
                  state_q <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               rdata   <= fetched;
               drive_q <= narrow ? 2'b01 : be_q;
               state_q <= ST_HOLD;
               ready   <= 1'b1;
            end
            ST_HOLD: if (release_c) begin
               state_q <= ST_IDLE;
               drive_q <= '0;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign rdata_en  = drive_q;
   assign ram_en    = (state_q == ST_ISSUE) && !ref_req;
   assign ram_we    = we_q;
   assign ram_addr  = addr_q;
   assign ram_be    = be_q;
   assign ram_wdata = wd_q;
endmodule

// File: rtl/gsd_host_bridge_chk.sv
module gsd_host_bridge_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        ready,
   input logic        ram_en,
   input logic        ram_we,
   input logic [1:0]  ram_be,
   input logic        ref_req,
   input logic        narrow,
   input logic        sel_n,
   input logic        rd_n,
   input logic [15:0] rdata,
   input logic [1:0]  rdata_en
);
   assert_refresh_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |-> !ref_req);

   assert_wait_during_ram_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ram_en |-> !ready);

   assert_write_has_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && ram_we) |-> (ram_be != 2'b00));

   assert_narrow_one_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && narrow) |-> ($countones(ram_be) == 1));

   assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rdata_en != 2'b00 && !sel_n && !rd_n) |=> ($stable(rdata) && $stable(rdata_en)));
endmodule

bind gsd_host_bridge gsd_host_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ready(ready), .ram_en(ram_en), .ram_we(ram_we),
   .ram_be(ram_be), .ref_req(ref_req), .narrow(narrow), .sel_n(sel_n),
   .rd_n(rd_n), .rdata(rdata), .rdata_en(rdata_en)
);

// File: tb/gsd_host_bridge_tb.sv
module gsd_host_bridge_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  place = 2'd2;
   logic        narrow = 1'b0;
   logic [16:0] addr = '0;
   logic        sel_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, ube_n = 1'b1;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [1:0]  rdata_en;
   logic        ready;
   logic        ref_req = 1'b0;
   logic        ram_en, ram_we;
   logic [13:0] ram_addr;
   logic [1:0]  ram_be;
   logic [15:0] ram_wdata;
   logic [15:0] ram_rdata = '0;
   logic [3:0]  pal_sel = '0;
   logic [5:0]  pal_level;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct {
      logic [13:0] a;
      logic        we;
      logic [1:0]  be;
      logic [15:0] d;
      string       req;
   } exp_t;
   exp_t sb[$];
   logic [15:0] mem [int];

   always #2 clk = ~clk;

   gsd_host_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .place(place), .narrow(narrow), .addr(addr),
      .sel_n(sel_n), .rd_n(rd_n), .wr_n(wr_n), .ube_n(ube_n), .wdata(wdata),
      .rdata(rdata), .rdata_en(rdata_en), .ready(ready), .ref_req(ref_req),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_be(ram_be),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .pal_sel(pal_sel),
      .pal_level(pal_level)
   );

   // RAM model, one cycle read latency
   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) begin
            logic [15:0] w;
            w = mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0;
            if (ram_be[0]) w[7:0]  = ram_wdata[7:0];
            if (ram_be[1]) w[15:8] = ram_wdata[15:8];
            mem[int'(ram_addr)] = w;
         end else begin
            ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 16'h0;
         end
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // scoreboard monitor for the RAM port
   always @(negedge clk) begin
      exp_t e;
      #1;
      if (rst_n && ram_en) begin
         if (sb.size() == 0) begin
            check(1'b0, "R3 unexpected RAM access", {17'h0, ram_addr}, 0);
         end else begin
            e = sb.pop_front();
            check(ram_addr == e.a && ram_we == e.we &&
                  (!e.we || (ram_be == e.be && ram_wdata == e.d)), e.req,
                  {ram_we, ram_be, ram_wdata[12:0], 2'b0, ram_addr},
                  {e.we, e.be, e.d[12:0], 2'b0, e.a});
         end
      end
   end

   task automatic push(input logic [13:0] a, input logic we, input logic [1:0] be,
                       input logic [15:0] d, input string req);
      exp_t e;
      e.a = a; e.we = we; e.be = be; e.d = d; e.req = req;
      sb.push_back(e);
   endtask

   // one host cycle; returns read data, lanes, wait count, hold/release status
   task automatic access(input logic [16:0] a, input logic is_wr, input logic ub_n,
                         input logic [15:0] d, input int ref_cycles,
                         output logic [15:0] rd, output logic [1:0] en,
                         output int waits, output bit held_ok, output bit rel_ok);
      int j;
      @(negedge clk);
      addr = a; wdata = d; ube_n = ub_n; sel_n = 1'b0;
      rd_n = is_wr; wr_n = !is_wr;
      ref_req = (ref_cycles > 0);
      j = 0; waits = 0;
      @(negedge clk); j++; ref_req = (j < ref_cycles);
      while (!ready) begin
         waits++;
         @(negedge clk); j++; ref_req = (j < ref_cycles);
      end
      rd = rdata; en = rdata_en;
      held_ok = 1'b1;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         if (rdata !== rd || rdata_en !== en) held_ok = 1'b0;
      end
      sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; ref_req = 1'b0;
      @(negedge clk);
      rel_ok = (rdata_en == 2'b00);
   endtask

   function automatic int stock(input int i);
      int t[16] = '{0, 4, 8, 12, 16, 19, 21, 23, 25, 27, 29, 32, 36, 40, 44, 48};
      return t[i];
   endfunction

   task automatic pal_look(input logic [3:0] i, input logic [5:0] exp, input string req);
      @(negedge clk);
      pal_sel = i;
      #1;
      check(pal_level == exp, req, pal_level, exp);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic [15:0] rd;
      logic [1:0]  en;
      int          w;
      bit          h, r;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ready == 1'b1, "R1 ready after reset", ready, 1);
      check(rdata_en == 2'b00, "R1 lanes idle after reset", rdata_en, 0);
      for (int i = 0; i < 16; i++) pal_look(4'(i), 6'(stock(i)), "R1 default level");

      // place 2: offsets 78h-EFh, lines 00h-9Fh
      place = 2'd2;
      push(14'd301, 1'b1, 2'b11, 16'hA5C3, "R2 R6 word write");
      access(17'h0057A, 1'b1, 1'b0, 16'hA5C3, 0, rd, en, w, h, r);
      check(w == 1, "R8 write wait cycles", w, 1);

      push(14'd301, 1'b0, 2'b11, 16'h0, "R2 word read issue");
      access(17'h0057A, 1'b0, 1'b0, 16'h0, 0, rd, en, w, h, r);
      check(w == 2, "R8 read wait cycles", w, 2);
      check(rd == 16'hA5C3 && en == 2'b11, "R6 word read data", {en, rd}, {2'b11, 16'hA5C3});
      check(h, "R10 read data held while strobes low", h, 1);
      check(r, "R10 lanes released", r, 1);

      push(14'd302, 1'b1, 2'b01, 16'hEE34, "R6 low lane write");
      access(17'h0057C, 1'b1, 1'b1, 16'hEE34, 0, rd, en, w, h, r);
      push(14'd302, 1'b1, 2'b10, 16'h56FF, "R6 high lane write");
      access(17'h0057D, 1'b1, 1'b0, 16'h56FF, 0, rd, en, w, h, r);
      push(14'd302, 1'b0, 2'b11, 16'h0, "R6 merged read issue");
      access(17'h0057C, 1'b0, 1'b0, 16'h0, 0, rd, en, w, h, r);
      check(rd == 16'h5634, "R6 lane merge", rd, 16'h5634);
      push(14'd302, 1'b0, 2'b01, 16'h0, "R6 low lane read issue");
      access(17'h0057C, 1'b0, 1'b1, 16'h0, 0, rd, en, w, h, r);
      check(en == 2'b01, "R6 low lane read mask", en, 2'b01);
      access(17'h0057D, 1'b1, 1'b1, 16'h1111, 0, rd, en, w, h, r);
      check(w == 0, "R6 no-lane cycle ignored", w, 0);

      // R7 narrow bus
      narrow = 1'b1;
      push(14'd363, 1'b1, 2'b10, 16'h7777, "R7 narrow write high byte");
      access(17'h0067F, 1'b1, 1'b0, 16'hFF77, 0, rd, en, w, h, r);
      push(14'd363, 1'b0, 2'b10, 16'h0, "R7 narrow read issue");
      access(17'h0067F, 1'b0, 1'b0, 16'h0, 0, rd, en, w, h, r);
      check(rd == 16'h0077 && en == 2'b01, "R7 narrow read high byte", {en, rd}, {2'b01, 16'h0077});
      push(14'd363, 1'b0, 2'b01, 16'h0, "R7 narrow read issue 2");
      access(17'h0067E, 1'b0, 1'b0, 16'h0, 0, rd, en, w, h, r);
      check(rd == 16'h0000 && en == 2'b01, "R7 narrow read low byte", {en, rd}, {2'b01, 16'h0000});
      narrow = 1'b0;

      // R3 misses for place 2
      access(17'h00510, 1'b1, 1'b0, 16'h1234, 0, rd, en, w, h, r);
      check(w == 0, "R3 foreign column write ignored", w, 0);
      access(17'h00510, 1'b0, 1'b0, 16'h0, 0, rd, en, w, h, r);
      check(en == 2'b00 && w == 0, "R3 foreign column read undriven", {w[13:0], en}, 0);
      access(17'h0A080, 1'b1, 1'b0, 16'h1234, 0, rd, en, w, h, r);
      check(w == 0, "R3 foreign line write ignored", w, 0);

      // place 1: offsets 00h-77h, lines A0h-13Fh
      place = 2'd1;
      push(14'd182, 1'b1, 2'b11, 16'h1357, "R2 place 1 address");
      access(17'h0A304, 1'b1, 1'b0, 16'h1357, 0, rd, en, w, h, r);
      access(17'h14004, 1'b1, 1'b0, 16'h2468, 0, rd, en, w, h, r);
      check(w == 0, "R3 line above 13Fh ignored", w, 0);

      // place 3: last word
      place = 2'd3;
      push(14'd9599, 1'b1, 2'b10, 16'h9900, "R2 place 3 last word");
      access(17'h13FEF, 1'b1, 1'b0, 16'h9900, 0, rd, en, w, h, r);

      // map entries, place 2
      place = 2'd2;
      access(17'h1FFC6, 1'b1, 1'b0, 16'hFFEA, 0, rd, en, w, h, r);
      check(w == 0, "R8 map write never waits", w, 0);
      pal_look(4'd3, 6'd42, "R4 map entry 3 written");
      access(17'h1FFC6, 1'b0, 1'b0, 16'h0, 0, rd, en, w, h, r);
      check(rd == 16'h002A && en == 2'b01, "R5 map read", {en, rd}, {2'b01, 16'h002A});
      access(17'h1FFA6, 1'b1, 1'b0, 16'h0005, 0, rd, en, w, h, r);
      pal_look(4'd3, 6'd42, "R4 other run ignored");
      access(17'h1FFC9, 1'b1, 1'b0, 16'h0007, 0, rd, en, w, h, r);
      pal_look(4'd4, 6'd16, "R4 odd address ignored");
      access(17'h1FFDE, 1'b1, 1'b0, 16'h0001, 0, rd, en, w, h, r);
      pal_look(4'd15, 6'd1, "R4 last entry written");

      // R9 refresh contention
      push(14'd4, 1'b1, 2'b11, 16'hBEEF, "R9 delayed write");
      access(17'h00080, 1'b1, 1'b0, 16'hBEEF, 4, rd, en, w, h, r);
      check(w == 4, "R9 write wait with 4 busy cycles", w, 4);
      push(14'd4, 1'b0, 2'b11, 16'h0, "R9 delayed read issue");
      access(17'h00080, 1'b0, 1'b0, 16'h0, 3, rd, en, w, h, r);
      check(w == 4, "R9 read wait with 3 busy cycles", w, 4);
      check(rd == 16'hBEEF, "R9 delayed read data", rd, 16'hBEEF);

      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R3 expected RAM accesses all seen", sb.size(), 0);
      finish_run();
   end
endmodule